// File: doc/BRIEF.md
# Streaming Row-Rotation Byte Permuter

This block applies the row-rotation step of a 512-bit byte-matrix hash round to a state that is streamed through a 128-bit datapath. The state is an 8x8 byte matrix. It arrives as four beats of 16 bytes, and each beat carries one pair of adjacent columns across all eight rows. The block rotates each row by its own row index and sends the result out in the same column-pair format. With a continuous input stream, each output beat appears four cycles after the input beat with the same index.

The byte storage is built from per-row shift chains. A capture chain per row gathers one block while a drain chain per row empties the previous block. When the fourth beat of a block arrives, the whole block is copied from the capture chains into the drain chains. The rotation is applied by the fixed byte selectors on that copy path. A block can also be marked raw. A raw block is loaded and sent out without rotation, which suits state that must be stored as it is. Consecutive blocks stream back to back, with no gap at the output.

Top module: `rowrot_stream`

## Requirements
- R1: While reset is active and in the first cycle after it is released, out_valid is 0 and out_data is all zero.
- R2: Within a beat, byte lane i (bits 8i+7:8i) holds row i/2, column 2k + (i mod 2), where k is the beat index (0 to 3) within the block. Input and output both use this layout.
- R3: For a block that is not raw, output row r, column c equals input row r, column (c - r) mod 8.
- R4: The first output beat of a block appears in the cycle after the block's fourth input beat is accepted. Output beat k follows k cycles later, so the four output beats occupy four consecutive cycles. When the input beats are contiguous, each output beat is four cycles behind its input beat.
- R5: Blocks fed back to back produce output beats in every cycle, with no bubble between blocks.
- R6: in_raw, sampled only on a block's first beat, makes the block come out with columns unrotated. Its value on the other three beats has no effect.
- R7: Cycles with in_valid low do not advance the block. in_data in those cycles is ignored.
- R8: Whenever out_valid is 0, out_data is all zero.
- R9: Reset discards a partly received block. out_valid never rises before four beats have been accepted since reset, and every output burst is a whole multiple of four beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_raw | input | 1 | Pass the block unrotated (sampled on first beat) |
| in_data | input | 128 | Column-pair beat, 16 bytes |
| out_valid | output | 1 | Output beat present |
| out_data | output | 128 | Permuted column-pair beat |

## Verification
Each output beat of a block falls due in the cycle after the block's fourth beat plus the beat's own index. With contiguous input this is four cycles after the matching input beat. The bench records the cycle number in which each fourth beat is driven and stores one expected beat with its due cycle for each output position. It samples on the falling edge and matches every valid output against the queue head, checking both the bytes and the cycle. If a due beat is missing when its cycle passes, or a beat arrives early, the check fails. In every idle cycle the bench also checks that the output bus is zero.

// File: rtl/rowrot_pkg.sv
package rowrot_pkg;
  // Source column feeding output column col of row row for a rotation by the row index.
  function automatic int src_col(input int row, input int col, input int ncols);
    int s;
    s = (col - row) % ncols;
    if (s < 0) s = s + ncols;
    return s;
  endfunction
endpackage

// File: rtl/rowrot_beat_ctr.sv
module rowrot_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic first_beat,
  output logic last_beat
);
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign first_beat = (cnt_q == '0);
  assign last_beat  = in_valid && (cnt_q == CW'(BEATS - 1));
  assign cnt_en     = in_valid;

  always_comb begin
    cnt_d = cnt_q;
    if (last_beat) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rowrot_row_capture.sv
module rowrot_row_capture #(
  parameter int LANES  = 2,
  parameter int COLS   = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_en,
  input  logic [LANES*BYTE_W-1:0]  pair_in,
  output logic [COLS*BYTE_W-1:0]   row_full
);
  localparam int ROW_W  = COLS * BYTE_W;
  localparam int PAIR_W = LANES * BYTE_W;

  logic [ROW_W-1:0] chain_q, chain_d;

  // New pair enters at the top; after a full block column 0 sits in the low byte.
  always_comb begin
    chain_d = {pair_in, chain_q[ROW_W-1:PAIR_W]};
  end

  // View of the row including the beat now on the input, used on the last beat.
  assign row_full = chain_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (shift_en) chain_q <= chain_d;
  end
endmodule

// File: rtl/rowrot_row_drain.sv
module rowrot_row_drain
  import rowrot_pkg::*;
#(
  parameter int ROW    = 0,
  parameter int LANES  = 2,
  parameter int COLS   = 8,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     raw,
  input  logic                     shift_en,
  input  logic [COLS*BYTE_W-1:0]   row_full,
  output logic [LANES*BYTE_W-1:0]  pair_out
);
  localparam int ROW_W  = COLS * BYTE_W;
  localparam int PAIR_W = LANES * BYTE_W;

  logic [ROW_W-1:0] held_q, held_d, loaded;

  // Byte selectors: only rows whose rotation is nonzero need a two-way choice.
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int SRC = src_col(ROW, c, COLS);
    if (SRC == c) begin : g_wire
      assign loaded[c*BYTE_W +: BYTE_W] = row_full[c*BYTE_W +: BYTE_W];
    end else begin : g_sel
      assign loaded[c*BYTE_W +: BYTE_W] = raw ? row_full[c*BYTE_W   +: BYTE_W]
                                              : row_full[SRC*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    held_d = held_q;
    if (load)          held_d = loaded;
    else if (shift_en) held_d = {{PAIR_W{1'b0}}, held_q[ROW_W-1:PAIR_W]};
  end

  assign pair_out = held_q[PAIR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                held_q <= '0;
    else if (load || shift_en) held_q <= held_d;
  end
endmodule

// File: rtl/rowrot_stream.sv
module rowrot_stream #(
  parameter int ROWS   = 8,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_raw,
  input  logic [ROWS*LANES*BYTE_W-1:0]  in_data,
  output logic                          out_valid,
  output logic [ROWS*LANES*BYTE_W-1:0]  out_data
);
  localparam int COLS   = ROWS;
  localparam int BEATS  = COLS / LANES;
  localparam int PAIR_W = LANES * BYTE_W;
  localparam int ROW_W  = COLS * BYTE_W;
  localparam int DW     = $clog2(BEATS + 1);

  logic          first_beat, last_beat;
  logic          raw_q, raw_d, raw_en, raw_eff;
  logic [DW-1:0] drain_q, drain_d;
  logic          drain_en, shift_out;

  rowrot_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .first_beat (first_beat),
    .last_beat  (last_beat)
  );

  // Raw flag belongs to the block: taken from its first beat only.
  assign raw_en  = in_valid && first_beat;
  assign raw_d   = in_raw;
  assign raw_eff = first_beat ? in_raw : raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= 1'b0;
    else if (raw_en) raw_q <= raw_d;
  end

  // Drain counter: beats still to emit from the drain chains.
  assign shift_out = (drain_q != '0);
  assign drain_en  = last_beat || shift_out;

  always_comb begin
    drain_d = drain_q;
    if (last_beat)      drain_d = DW'(BEATS);
    else if (shift_out) drain_d = drain_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        drain_q <= '0;
    else if (drain_en) drain_q <= drain_d;
  end

  assign out_valid = shift_out;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [ROW_W-1:0] full;

    rowrot_row_capture #(.LANES(LANES), .COLS(COLS), .BYTE_W(BYTE_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .pair_in  (in_data[r*PAIR_W +: PAIR_W]),
      .row_full (full)
    );

    rowrot_row_drain #(.ROW(r), .LANES(LANES), .COLS(COLS), .BYTE_W(BYTE_W)) u_drn (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (last_beat),
      .raw      (raw_eff),
      .shift_en (shift_out),
      .row_full (full),
      .pair_out (out_data[r*PAIR_W +: PAIR_W])
    );
  end
endmodule

// File: rtl/rowrot_stream_chk.sv
module rowrot_stream_chk #(
  parameter int ROWS   = 8,
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_raw,
  input logic [ROWS*LANES*BYTE_W-1:0]  in_data,
  input logic                          out_valid,
  input logic [ROWS*LANES*BYTE_W-1:0]  out_data
);
  localparam int BEATS = ROWS / LANES;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CW-1:0] in_cnt_q, run_q;
  logic          seen_block_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt_q     <= '0;
      run_q        <= '0;
      seen_block_q <= 1'b0;
    end else begin
      if (in_valid) begin
        in_cnt_q <= (in_cnt_q == CW'(BEATS - 1)) ? '0 : in_cnt_q + CW'(1);
        if (in_cnt_q == CW'(BEATS - 1)) seen_block_q <= 1'b1;
      end
      if (out_valid) run_q <= (run_q == CW'(BEATS - 1)) ? '0 : run_q + CW'(1);
    end
  end

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0)); // R8

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen_block_q); // R9

  AST_WHOLE_BURSTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (run_q == '0)); // R9

  AST_START_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(in_valid) && ($past(in_cnt_q) == CW'(BEATS - 1)))); // R4

  AST_BLOCK_STARTS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_cnt_q == CW'(BEATS - 1))) |=> out_valid); // R5
endmodule

bind rowrot_stream rowrot_stream_chk #(.ROWS(ROWS), .LANES(LANES), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/rowrot_stream_bench.sv
module rowrot_stream_bench;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int DW   = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_raw = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q[$];
  int            due_q[$];
  int            tag_q[$];

  rowrot_stream u_rowrot_stream (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_raw(in_raw),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Stimulus table: seed, raw flag, idle cycles inside block, idle cycles after block, tag.
  localparam int NV = 8;
  localparam int V_SEED [NV] = '{11, 23, 37, 41, 59, 67, 73, 89};
  localparam int V_RAW  [NV] = '{0, 0, 0, 1, 0, 1, 0, 0};
  localparam int V_GAP  [NV] = '{0, 0, 0, 0, 3, 0, 1, 0};
  localparam int V_IDLE [NV] = '{0, 0, 2, 0, 0, 0, 5, 0};
  localparam int V_TAG  [NV] = '{2, 5, 3, 6, 7, 6, 7, 3};

  function automatic string tname(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] gb(input int seed, input int r, input int c);
    int v;
    v = seed * 1103515245 + r * 12345 + c * 2654435 + 977;
    v = v ^ (v >>> 13);
    v = v * 69069 + seed;
    return v[23:16] ^ v[7:0];
  endfunction

  // Input beat k: lane 2r+p carries row r, column 2k+p.
  function automatic logic [DW-1:0] in_beat(input int seed, input int k);
    logic [DW-1:0] d;
    for (int r = 0; r < ROWS; r++)
      for (int p = 0; p < 2; p++)
        d[(2*r+p)*8 +: 8] = gb(seed, r, 2*k+p);
    return d;
  endfunction

  // Model of the output beat: row r, column c takes column (c-r) mod 8, or c if raw.
  function automatic logic [DW-1:0] out_beat(input int seed, input int k, input bit raw);
    logic [DW-1:0] d;
    int src;
    for (int r = 0; r < ROWS; r++)
      for (int p = 0; p < 2; p++) begin
        src = raw ? (2*k+p) : (((2*k+p) - r + COLS) % COLS);
        d[(2*r+p)*8 +: 8] = gb(seed, r, src);
      end
    return d;
  endfunction

  task automatic check(input bit ok, input int tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tname(tag), what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_valid = 1'b0;
      in_data  = {4{$urandom}};
    end
  endtask

  task automatic send_block(input int seed, input bit raw, input int gap, input int tag);
    int last_cyc;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      in_valid = 1'b1;
      in_data  = in_beat(seed, k);
      in_raw   = (k == 0) ? raw : ~raw;  // only first beat counts (R6)
      last_cyc = cyc;
      if (k == 1 && gap > 0) idle(gap);   // gap cycles carry junk data (R7)
    end
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(out_beat(seed, k, raw));
      due_q.push_back(last_cyc + 1 + k);
      tag_q.push_back(tag);
    end
  endtask

  // Output monitor: compare every beat against the queue head, in its due cycle.
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, 9, out_data, '0, "unexpected output beat");
        end else begin
          logic [DW-1:0] e;
          int d, t;
          e = exp_q.pop_front(); d = due_q.pop_front(); t = tag_q.pop_front();
          check(out_data == e, t, out_data, e, "beat data");
          check(cyc == d, 4, DW'(cyc), DW'(d), "beat cycle");
        end
      end else begin
        check(out_data == '0, 8, out_data, '0, "idle bus not zero");
        if (due_q.size() > 0 && due_q[0] <= cyc) begin
          check(1'b0, 4, DW'(cyc), DW'(due_q[0]), "beat missing at due cycle");
          void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, 9, DW'(cyc), '0, "watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, during and just after reset
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, 1, out_data, '0, "reset state");
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, 1, out_data, '0, "first cycle after reset");
    running = 1'b1;

    // Table walk: contiguous, back to back, raw, gapped blocks
    for (int i = 0; i < NV; i++) begin
      send_block(V_SEED[i], V_RAW[i] != 0, V_GAP[i], V_TAG[i]);
      if (V_IDLE[i] > 0) idle(V_IDLE[i]);
    end
    idle(8);
    check(exp_q.size() == 0, 4, DW'(exp_q.size()), '0, "all table beats delivered");

    // R9: partial block then reset; leftover beats must be forgotten
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      in_valid = 1'b1; in_data = in_beat(501, k); in_raw = 1'b0;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    running = 1'b0;
    rst_n = 1'b0;
    exp_q.delete(); due_q.delete(); tag_q.delete();
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, 1, out_data, '0, "mid-run reset clears output");
    #1 rst_n = 1'b1;
    running = 1'b1;
    idle(2);
    send_block(601, 1'b0, 0, 9);
    send_block(602, 1'b1, 0, 6);
    send_block(603, 1'b0, 2, 3);
    idle(10);
    check(exp_q.size() == 0, 9, DW'(exp_q.size()), '0, "post-reset blocks delivered");
    check(out_valid == 1'b0, 9, DW'(out_valid), '0, "no stray burst after drain");
    running = 1'b0;
    finish_run();
  end
endmodule